// File: doc/BRIEF.md
# Frequency Counter Gate Sequencer

This block turns one reference clock into the three control strobes of a gated frequency counter. A prescaler divides the reference into a timebase tick, and a toggle stage halves that tick into a square gate window. The gate-open and gate-closed intervals are therefore equal. While the gate is high the external counter chain counts the unknown signal.

Every time the window closes, the block waits a set number of reference cycles, then raises a latch pulse so the display registers can capture the count. It waits again and then raises a clear pulse that zeroes the counters. All spacing and widths are counted in reference cycles, so they cannot race, oscillate or drift with temperature. A one-cycle done strobe marks the end of each latch pulse.

The block has no data stream, so there is no valid/ready handshake and no back-pressure. All pins are plain control signals, and all outputs are registered and active-high.

Top module: `fcs_gate_sequencer`

## Requirements
- R1: The gate output changes level only on a timebase tick, and a tick occurs every PRE_DIV reference cycles. After a synchronous reset is released, the gate first rises on the PRE_DIV-th clock edge.
- R2: The gate stays high for exactly PRE_DIV cycles and low for exactly PRE_DIV cycles.
- R3: Let the gate fall on edge E. The latch output rises on edge E+GAP_PRE and stays high for exactly LAT_W cycles.
- R4: The clear output rises GAP_POST cycles after the latch output falls and stays high for exactly CLR_W cycles.
- R5: The latch and clear outputs are never high together, and neither is high while the gate is high.
- R6: The clear output is low for at least one cycle before the gate rises. Elaboration fails unless GAP_PRE+LAT_W+GAP_POST+CLR_W+1 <= PRE_DIV and every one of these four values is at least 1.
- R7: The done output is high for exactly one cycle, the cycle that follows the clock edge on which the latch output falls.
- R8: While the synchronous reset is high, every output is low after each clock edge and all dividers restart from zero.
- R9: The closed interval that comes right after a reset produces no latch, clear or done pulse, because no gate window preceded it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; every interval is counted in its cycles |
| srst | input | 1 | Synchronous reset, active-high |
| gate_o | output | 1 | Counting window, high while the counters may count |
| latch_o | output | 1 | Pulse that copies the count into the display registers |
| clr_o | output | 1 | Pulse that clears the counter chain |
| done_o | output | 1 | One-cycle strobe on the cycle the latch pulse ends |

## Verification
The bench sweeps every clock cycle of a small configuration across several complete gate periods. For each cycle it computes the expected level of all four outputs from that cycle's distance to the last reset release. This separates a prescaler that is off by one from a wrong gap or a wrong pulse width. It also catches a sequence that starts on the gate opening instead of the gate closing. A reset is applied in the middle of a latch pulse: the outputs must drop at once, and the first closed interval after the reset must stay silent. This separates a design that truly restarts its dividers from one that only masks its outputs.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_GAPA  = 3'd1,
    PH_LATCH = 3'd2,
    PH_GAPB  = 3'd3,
    PH_CLEAR = 3'd4
  } fcs_phase_e;
endpackage

// File: rtl/fcs_prescaler.sv
module fcs_prescaler #(
  parameter int PRE_DIV = 1000
) (
  input  logic clk_ref,
  input  logic srst,
  output logic tick_o
);
  localparam int CW = $clog2(PRE_DIV + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(PRE_DIV - 1));

  always_ff @(posedge clk_ref) begin
    if (srst)        cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_ref) disable iff (srst)
    cnt_q < CW'(PRE_DIV)); // R1
  AST_PRESCALE_RESTART: assert property (@(posedge clk_ref)
    srst |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/fcs_gate_toggle.sv
module fcs_gate_toggle (
  input  logic clk_ref,
  input  logic srst,
  input  logic tick_i,
  output logic gate_o,
  output logic close_o
);
  logic gate_q;

  always_ff @(posedge clk_ref) begin
    if (srst)        gate_q <= 1'b0;
    else if (tick_i) gate_q <= ~gate_q;
  end

  assign gate_o  = gate_q;
  assign close_o = tick_i & gate_q;

  AST_GATE_ONLY_ON_TICK: assert property (@(posedge clk_ref) disable iff (srst)
    !tick_i |=> $stable(gate_q)); // R1
endmodule

// File: rtl/fcs_pulse_seq.sv
module fcs_pulse_seq
  import fcs_pkg::*;
#(
  parameter int PRE_DIV  = 1000,
  parameter int GAP_PRE  = 100,
  parameter int LAT_W    = 50,
  parameter int GAP_POST = 100,
  parameter int CLR_W    = 50
) (
  input  logic clk_ref,
  input  logic srst,
  input  logic close_i,
  output logic latch_o,
  output logic clr_o,
  output logic done_o
);
  localparam int CW = $clog2(PRE_DIV + 1);

  fcs_phase_e    phase_q, phase_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          latch_q, clr_q, done_q;
  logic          last_w;

  assign last_w = (cnt_q == '0);

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    if (close_i) begin
      phase_n = PH_GAPA;
      cnt_n   = CW'(GAP_PRE - 1);
    end else if (phase_q != PH_IDLE) begin
      if (!last_w) begin
        cnt_n = cnt_q - 1'b1;
      end else begin
        unique case (phase_q)
          PH_GAPA:  begin phase_n = PH_LATCH; cnt_n = CW'(LAT_W - 1);    end
          PH_LATCH: begin phase_n = PH_GAPB;  cnt_n = CW'(GAP_POST - 1); end
          PH_GAPB:  begin phase_n = PH_CLEAR; cnt_n = CW'(CLR_W - 1);    end
          default:  begin phase_n = PH_IDLE;  cnt_n = '0;                end
        endcase
      end
    end
  end

  always_ff @(posedge clk_ref) begin
    if (srst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      latch_q <= 1'b0;
      clr_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      latch_q <= (phase_n == PH_LATCH);
      clr_q   <= (phase_n == PH_CLEAR);
      done_q  <= (phase_q == PH_LATCH) && last_w && !close_i;
    end
  end

  assign latch_o = latch_q;
  assign clr_o   = clr_q;
  assign done_o  = done_q;

  AST_DONE_ON_LATCH_FALL: assert property (@(posedge clk_ref) disable iff (srst)
    $fell(latch_q) |-> done_q); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_ref) disable iff (srst)
    done_q |=> !done_q); // R7
  AST_CLEAR_AFTER_GAP: assert property (@(posedge clk_ref) disable iff (srst)
    $rose(clr_q) |-> !$past(latch_q)); // R4
endmodule

// File: rtl/fcs_gate_sequencer.sv
module fcs_gate_sequencer #(
  parameter int PRE_DIV  = 1000,
  parameter int GAP_PRE  = 100,
  parameter int LAT_W    = 50,
  parameter int GAP_POST = 100,
  parameter int CLR_W    = 50
) (
  input  logic clk_ref,
  input  logic srst,
  output logic gate_o,
  output logic latch_o,
  output logic clr_o,
  output logic done_o
);
  localparam int SEQ_SPAN = GAP_PRE + LAT_W + GAP_POST + CLR_W;

  if (SEQ_SPAN + 1 > PRE_DIV || GAP_PRE < 1 || LAT_W < 1 ||
      GAP_POST < 1 || CLR_W < 1) begin : g_bad_cfg
    $error("fcs_gate_sequencer: pulse sequence does not fit the closed gate interval");
  end

  logic tick_w, close_w, gate_w;

  fcs_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_ref (clk_ref),
    .srst    (srst),
    .tick_o  (tick_w)
  );

  fcs_gate_toggle u_tog (
    .clk_ref (clk_ref),
    .srst    (srst),
    .tick_i  (tick_w),
    .gate_o  (gate_w),
    .close_o (close_w)
  );

  fcs_pulse_seq #(
    .PRE_DIV  (PRE_DIV),
    .GAP_PRE  (GAP_PRE),
    .LAT_W    (LAT_W),
    .GAP_POST (GAP_POST),
    .CLR_W    (CLR_W)
  ) u_seq (
    .clk_ref (clk_ref),
    .srst    (srst),
    .close_i (close_w),
    .latch_o (latch_o),
    .clr_o   (clr_o),
    .done_o  (done_o)
  );

  assign gate_o = gate_w;

  AST_NO_PULSE_IN_WINDOW: assert property (@(posedge clk_ref) disable iff (srst)
    gate_w |-> (!latch_o && !clr_o)); // R5
  AST_LATCH_CLEAR_EXCL: assert property (@(posedge clk_ref) disable iff (srst)
    !(latch_o && clr_o)); // R5
  AST_CLEAR_LOW_BEFORE_OPEN: assert property (@(posedge clk_ref) disable iff (srst)
    $rose(gate_w) |-> !$past(clr_o)); // R6
  AST_RESET_SILENCE: assert property (@(posedge clk_ref)
    srst |=> (!gate_w && !latch_o && !clr_o && !done_o)); // R8
endmodule

// File: tb/fcs_gate_sequencer_tb_top.sv
`timescale 1ns/1ps
module fcs_gate_sequencer_tb_top;
  localparam int PD = 20;
  localparam int G1 = 2;
  localparam int LW = 3;
  localparam int G2 = 4;
  localparam int CW = 2;

  logic clk_ref = 1'b0;
  logic srst    = 1'b1;
  logic gate_o, latch_o, clr_o, done_o;

  int errors = 0;
  int checks = 0;
  int n      = 0;
  int hi_run = 0;
  logic prev_gate = 1'b0;
  logic prev_clr  = 1'b0;

  always #2.5 clk_ref = ~clk_ref;

  fcs_gate_sequencer #(
    .PRE_DIV(PD), .GAP_PRE(G1), .LAT_W(LW), .GAP_POST(G2), .CLR_W(CW)
  ) dut_i (
    .clk_ref (clk_ref),
    .srst    (srst),
    .gate_o  (gate_o),
    .latch_o (latch_o),
    .clr_o   (clr_o),
    .done_o  (done_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, n, act, exp);
    end
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    for (int s = 0; s < 460; s++) begin
      @(negedge clk_ref);
      srst = (s < 3) || (s >= 3 + 43 && s < 3 + 45);
      @(posedge clk_ref);
      if (srst) n = 0; else n = n + 1;
      #1;
      begin
        int  c;
        bit  seq;
        int  eg, el, ec, ed;
        c   = n % (2 * PD);
        seq = (n >= 2 * PD);
        eg  = ((n / PD) % 2 == 1) ? 1 : 0;
        el  = (seq && c >= G1 && c < G1 + LW) ? 1 : 0;
        ec  = (seq && c >= G1 + LW + G2 && c < G1 + LW + G2 + CW) ? 1 : 0;
        ed  = (seq && c == G1 + LW) ? 1 : 0;
        if (srst) begin
          chk("R8", {28'd0, gate_o, latch_o, clr_o, done_o}, 0);
        end else begin
          chk("R1", gate_o, eg);                       // R1 gate timing
          chk(seq ? "R3" : "R9", latch_o, el);         // R3 / R9
          chk(seq ? "R4" : "R9", clr_o, ec);           // R4 / R9
          chk("R7", done_o, ed);                       // R7
          chk("R5", (latch_o & clr_o) | (gate_o & (latch_o | clr_o)), 0);
          if (gate_o && !prev_gate) chk("R6", prev_clr, 0);
          if (!gate_o && prev_gate) chk("R2", hi_run, PD);
        end
        hi_run    = (gate_o && !srst) ? hi_run + 1 : 0;
        prev_gate = gate_o;
        prev_clr  = clr_o;
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule